// File: doc/BRIEF.md
# Single-Word DMA Host Engine for an ATA Device Port

This block is the host half of an ATA single-word DMA transfer. A controller programs a direction, a timing mode and a word count, then pulses a start input. From then on the engine serves the device one 16-bit word per request. The device raises its request line. The host answers by asserting its active-low acknowledge and issuing exactly one read or write strobe of the mode's length. It then releases the acknowledge and waits for a new request edge before it serves the next word.

Words read from the device leave through a ready/valid stream. Words written to the device are taken from a second ready/valid stream. The engine stalls, with no acknowledge and no strobe, while the write source has nothing to offer or while the read holding register is still occupied. All timings are whole counts of the system clock, rounded up from nanosecond minimums through the `CLK_NS` parameter. Mode 0 is the slowest and mode 2 the fastest. A one-cycle done pulse reports that the last programmed word has been moved.

Top module: `swdma_host`

## Requirements
- R1: During and right after reset, `dev_ack_n`, `dev_rd_n` and `dev_wr_n` are high, and `dev_dd_oe`, `xfer_busy`, `xfer_done`, `rx_valid` and `tx_ready` are low.
- R2: The request input passes through two synchronizing flops. With the engine waiting and able to move a word, `dev_ack_n` falls on the third rising edge after `dev_req` rises. A strobe is only ever low while `dev_ack_n` is low, and the read and write strobes are never low together.
- R3: Each strobe stays low for ceil(T/CLK_NS) cycles, where T is 480 ns in mode 0, 240 ns in mode 1 and 120 ns in mode 2 (60, 30 and 15 cycles at 8 ns). Mode code 3 times like mode 2. Mode and direction are captured at start, and later changes on `xfer_mode` have no effect on that transfer.
- R4: Two successive falls of `dev_ack_n` are at least ceil(C/CLK_NS) cycles apart, where C is 960, 480 or 240 ns for modes 0, 1 and 2 (120, 60 and 30 cycles).
- R5: On a write (`xfer_write`=1), a word accepted on `tx_data` is driven on `dev_dd_out`, with `dev_dd_oe` high, from the acknowledge through the strobe. It stays driven and unchanged for ceil(H/CLK_NS) cycles after `dev_wr_n` rises, with H = 50, 30 and 20 ns (7, 4 and 3 cycles). Words reach the device in stream order.
- R6: On a read (`xfer_write`=0), `dev_dd_in` is sampled on the final clock edge of the strobe. It is then presented on `rx_data` with `rx_valid` high, held unchanged until `rx_ready` is seen high.
- R7: After every strobe the acknowledge is released. The next word starts only after the synchronized request has been seen low since the previous acknowledge and then high again. A request held high keeps the engine from starting another word.
- R8: While the write stream offers no word, or while `rx_valid` is still high, a pending request gets no acknowledge and no strobe. The transfer resumes once the stream condition clears.
- R9: Exactly `xfer_words` strobes are issued. `xfer_done` is then high for a single cycle and `xfer_busy` returns low. A start with a count of zero yields the done pulse with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle pulse that begins a transfer when idle |
| xfer_write | input | 1 | 1 = host to device, 0 = device to host |
| xfer_mode | input | 2 | Timing mode 0, 1 or 2 (3 acts as 2) |
| xfer_words | input | CNT_W | Number of words to move |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse after the last word |
| dev_req | input | 1 | Device DMA request, asynchronous |
| dev_ack_n | output | 1 | Host acknowledge, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dd_in | input | DW | Data bus from the device |
| dev_dd_out | output | DW | Data bus toward the device |
| dev_dd_oe | output | 1 | Drive enable for `dev_dd_out` |
| rx_data | output | DW | Word read from the device |
| rx_valid | output | 1 | `rx_data` holds a word |
| rx_ready | input | 1 | Consumer takes the read word |
| tx_data | input | DW | Word to write to the device |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Engine takes the write word |

## Verification
A phase counter that is loaded wrongly shows up as a strobe of the wrong width, which is visible within one word. A cycle counter that is wrong shows up as acknowledge falls spaced too closely, visible by the second word. A lost request-history flag appears either as a second acknowledge while the device still holds its request, or as a transfer that never finishes.

A word counter that drifts is visible at the done pulse as a strobe total that differs from the programmed count. Corruption in the read holding register or the write data register is visible on the first word as a mismatched value or an out-of-order stream entry.

// File: rtl/swdma_pkg.sv
package swdma_pkg;

    localparam int unsigned TIM_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_STB,
        ST_HOLD,
        ST_RECOV
    } swdma_state_e;

    typedef struct packed {
        logic [TIM_W-1:0] strobe;
        logic [TIM_W-1:0] cycle;
        logic [TIM_W-1:0] hold;
    } swdma_tim_t;

    // Round a nanosecond minimum up to whole clocks, never below one.
    function automatic logic [TIM_W-1:0] ns_to_cyc(input int unsigned ns,
                                                   input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return TIM_W'(c);
    endfunction

    // Per-mode strobe width, full word period and write data hold.
    function automatic swdma_tim_t mode_timing(input logic [1:0] mode,
                                               input int unsigned clk_ns);
        swdma_tim_t t;
        int unsigned s_ns, c_ns, h_ns;
        case (mode)
            2'd0:    begin s_ns = 480; c_ns = 960; h_ns = 50; end
            2'd1:    begin s_ns = 240; c_ns = 480; h_ns = 30; end
            default: begin s_ns = 120; c_ns = 240; h_ns = 20; end
        endcase
        t.strobe = ns_to_cyc(s_ns, clk_ns);
        t.cycle  = ns_to_cyc(c_ns, clk_ns);
        t.hold   = ns_to_cyc(h_ns, clk_ns);
        return t;
    endfunction

endpackage

// File: rtl/swdma_sync.sv
module swdma_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/swdma_downcnt.sv
module swdma_downcnt #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/swdma_rxbuf.sv
module swdma_rxbuf #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (capture) begin
            valid <= 1'b1;
            data  <= din;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/swdma_host.sv
module swdma_host
    import swdma_pkg::*;
#(
    parameter int unsigned CLK_NS      = 8,
    parameter int unsigned DW          = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_start,
    input  logic             xfer_write,
    input  logic [1:0]       xfer_mode,
    input  logic [CNT_W-1:0] xfer_words,
    output logic             xfer_busy,
    output logic             xfer_done,
    input  logic             dev_req,
    output logic             dev_ack_n,
    output logic             dev_rd_n,
    output logic             dev_wr_n,
    input  logic [DW-1:0]    dev_dd_in,
    output logic [DW-1:0]    dev_dd_out,
    output logic             dev_dd_oe,
    output logic [DW-1:0]    rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    input  logic [DW-1:0]    tx_data,
    input  logic             tx_valid,
    output logic             tx_ready
);

    swdma_state_e     state_q, state_d;
    swdma_tim_t       tim_q;
    logic             dir_q;
    logic             fresh_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    dd_q;
    logic             req_s;
    logic             go;
    logic             ph_load, ph_zero;
    logic [TIM_W-1:0] ph_val;
    logic             cyc_load, cyc_zero;
    logic             cap_rd, cnt_dec, done_d;
    logic             ack_n_q, rd_n_q, wr_n_q, oe_q, done_q;

    // Request crosses into the clock domain.
    swdma_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (dev_req),
        .q   (req_s)
    );

    // Time inside one phase (strobe, hold).
    swdma_downcnt #(.W(TIM_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    // Full word period measured from the acknowledge.
    swdma_downcnt #(.W(TIM_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .load     (cyc_load),
        .load_val (tim_q.cycle - TIM_W'(1)),
        .zero     (cyc_zero)
    );

    // One-word holding register toward the read consumer.
    swdma_rxbuf #(.W(DW)) u_rxbuf (
        .clk     (clk),
        .rst     (rst),
        .capture (cap_rd),
        .din     (dev_dd_in),
        .ready   (rx_ready),
        .valid   (rx_valid),
        .data    (rx_data)
    );

    assign tx_ready = (state_q == ST_WAIT) && dir_q && req_s && fresh_q;
    assign go       = (state_q == ST_WAIT) && req_s && fresh_q &&
                      (dir_q ? tx_valid : !rx_valid);

    always_comb begin
        state_d  = state_q;
        ph_load  = 1'b0;
        ph_val   = '0;
        cyc_load = 1'b0;
        cap_rd   = 1'b0;
        cnt_dec  = 1'b0;
        done_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (xfer_start) begin
                    if (xfer_words == '0) done_d  = 1'b1;
                    else                  state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (go) begin
                    state_d  = ST_ACK;
                    cyc_load = 1'b1;
                end
            end
            ST_ACK: begin
                state_d = ST_STB;
                ph_load = 1'b1;
                ph_val  = tim_q.strobe - TIM_W'(1);
            end
            ST_STB: begin
                if (ph_zero) begin
                    state_d = ST_HOLD;
                    ph_load = 1'b1;
                    ph_val  = tim_q.hold - TIM_W'(1);
                    cap_rd  = !dir_q;
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD: begin
                if (ph_zero) state_d = ST_RECOV;
            end
            ST_RECOV: begin
                if (cyc_zero && fresh_q) begin
                    if (cnt_q == '0) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tim_q   <= '0;
            dir_q   <= 1'b0;
            cnt_q   <= '0;
            fresh_q <= 1'b0;
            dd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && xfer_start) begin
                tim_q <= mode_timing(xfer_mode, CLK_NS);
                dir_q <= xfer_write;
                cnt_q <= xfer_words;
            end else if (cnt_dec) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (go)          fresh_q <= 1'b0;
            else if (!req_s) fresh_q <= 1'b1;
            if (go && dir_q) dd_q <= tx_data;
        end
    end

    // Pin drivers registered from the next state: clean edges, one flop deep.
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_n_q <= 1'b1;
            rd_n_q  <= 1'b1;
            wr_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ack_n_q <= !(state_d inside {ST_ACK, ST_STB, ST_HOLD});
            rd_n_q  <= !(state_d == ST_STB && !dir_q);
            wr_n_q  <= !(state_d == ST_STB && dir_q);
            oe_q    <= dir_q && (state_d inside {ST_ACK, ST_STB, ST_HOLD});
            done_q  <= done_d;
        end
    end

    assign dev_ack_n  = ack_n_q;
    assign dev_rd_n   = rd_n_q;
    assign dev_wr_n   = wr_n_q;
    assign dev_dd_oe  = oe_q;
    assign dev_dd_out = dd_q;
    assign xfer_done  = done_q;
    assign xfer_busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/swdma_host_chk.sv
module swdma_host_chk #(
    parameter int unsigned DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          dev_ack_n,
    input logic          dev_rd_n,
    input logic          dev_wr_n,
    input logic          dev_dd_oe,
    input logic [DW-1:0] dev_dd_out,
    input logic          xfer_done,
    input logic          xfer_busy,
    input logic [DW-1:0] rx_data,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          tx_valid,
    input logic          dir_q
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dev_ack_n && dev_rd_n && dev_wr_n && !dev_dd_oe && !xfer_busy));

    // R2
    strobe_under_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!dev_rd_n || !dev_wr_n) |-> !dev_ack_n);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_rd_n || dev_wr_n));

    // R5
    wr_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !dev_wr_n |-> dev_dd_oe);

    // R5
    bus_hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_dd_oe && $past(dev_dd_oe)) |-> $stable(dev_dd_out));

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R8
    ack_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(dev_ack_n) && dir_q) |-> $past(tx_valid));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);
endmodule

bind swdma_host swdma_host_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dev_ack_n  (dev_ack_n),
    .dev_rd_n   (dev_rd_n),
    .dev_wr_n   (dev_wr_n),
    .dev_dd_oe  (dev_dd_oe),
    .dev_dd_out (dev_dd_out),
    .xfer_done  (xfer_done),
    .xfer_busy  (xfer_busy),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .dir_q      (dir_q)
);

// File: tb/swdma_host_tb.sv
module swdma_host_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_start = 1'b0;
    logic        xfer_write = 1'b0;
    logic [1:0]  xfer_mode = 2'd0;
    logic [15:0] xfer_words = '0;
    logic        xfer_busy, xfer_done;
    logic        dev_req = 1'b0;
    logic        dev_ack_n, dev_rd_n, dev_wr_n, dev_dd_oe;
    logic [15:0] dev_dd_in = '0;
    logic [15:0] dev_dd_out;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic [15:0] tx_data = 16'h3C00;
    logic        tx_valid = 1'b0;
    logic        tx_ready;

    always #4 clk = ~clk;

    swdma_host u_dut (
        .clk(clk), .rst(rst),
        .xfer_start(xfer_start), .xfer_write(xfer_write), .xfer_mode(xfer_mode),
        .xfer_words(xfer_words), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .dev_req(dev_req), .dev_ack_n(dev_ack_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
        .dev_dd_in(dev_dd_in), .dev_dd_out(dev_dd_out), .dev_dd_oe(dev_dd_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    // Controls written by the main sequence only.
    int  clr_gen = 0, drop_gen = 0, dev_words = 0;
    bit  dev_stick = 1'b0, src_en = 1'b1, sink_en = 1'b1;
    int  n_chk = 0, n_fail = 0;

    // State written by the device / monitor process only.
    int  clr_seen = 0, drop_seen = 0;
    int  n_stb, stb_w, stb_min, stb_max, n_ack, ack_gap, gap_min, hold_last, hold_run;
    int  n_w, n_r, n_done, lat_cnt, lat_last, tx_idx, gapc;
    bit  in_hold, lat_on, lat_arm, tx_pend, strb, prev_strb, prev_wr, prev_ack_n = 1'b1;
    logic [15:0] wr_seen;
    logic [15:0] wlog [0:7];
    logic [15:0] rlog [0:7];

    // Device model, stream source/sink and pin monitor, all at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (clr_gen != clr_seen) begin
                clr_seen = clr_gen;
                n_stb = 0; stb_w = 0; stb_min = 1000000; stb_max = 0;
                n_ack = 0; ack_gap = 0; gap_min = 1000000;
                hold_last = -1; hold_run = 0; in_hold = 1'b0;
                n_w = 0; n_r = 0; n_done = 0;
                lat_cnt = 0; lat_on = 1'b0; lat_arm = 1'b1; lat_last = -1;
                tx_idx = 0; tx_data = 16'h3C00; tx_pend = 1'b0;
            end
            tx_valid = src_en;
            rx_ready = sink_en;
            strb = !dev_rd_n || !dev_wr_n;
            if (strb) begin
                stb_w++;
                if (!dev_wr_n) wr_seen = dev_dd_out;
            end else if (prev_strb) begin
                if (stb_w < stb_min) stb_min = stb_w;
                if (stb_w > stb_max) stb_max = stb_w;
                stb_w = 0;
                n_stb++;
                if (prev_wr) begin
                    if (n_w < 8) wlog[n_w] = wr_seen;
                    n_w++;
                    in_hold = 1'b1;
                    hold_run = 0;
                end
            end
            if (in_hold) begin
                if (dev_dd_oe) hold_run++;
                else begin hold_last = hold_run; in_hold = 1'b0; end
            end
            if (prev_ack_n && !dev_ack_n) begin
                if (n_ack > 0 && ack_gap < gap_min) gap_min = ack_gap;
                ack_gap = 0;
                n_ack++;
                if (lat_on) begin lat_last = lat_cnt; lat_on = 1'b0; end
            end
            ack_gap++;
            if (lat_on) lat_cnt++;
            if (xfer_done) n_done++;
            if (rx_valid && rx_ready) begin
                if (n_r < 8) rlog[n_r] = rx_data;
                n_r++;
            end
            if (tx_pend) begin
                tx_idx++;
                tx_data = 16'h3C00 + 16'(tx_idx);
                tx_pend = 1'b0;
            end
            if (tx_valid && tx_ready) tx_pend = 1'b1;
            if (drop_gen != drop_seen) begin
                drop_seen = drop_gen;
                dev_req = 1'b0;
                gapc = 0;
            end else if (dev_req && !dev_ack_n && !dev_stick) begin
                dev_req = 1'b0;
                gapc = 0;
            end else if (!dev_req && dev_ack_n && n_ack < dev_words) begin
                gapc++;
                if (gapc >= 2) begin
                    dev_req = 1'b1;
                    if (lat_arm) begin lat_arm = 1'b0; lat_on = 1'b1; lat_cnt = 0; end
                end
            end
            if (!dev_rd_n) dev_dd_in = 16'hA500 ^ 16'(n_stb);
            prev_strb  = strb;
            prev_wr    = !dev_wr_n;
            prev_ack_n = dev_ack_n;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim, input string what);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    function automatic int exp_stb(input int m);
        return (m == 0) ? 60 : (m == 1) ? 30 : 15;
    endfunction
    function automatic int exp_cyc(input int m);
        return (m == 0) ? 120 : (m == 1) ? 60 : 30;
    endfunction
    function automatic int exp_hold(input int m);
        return (m == 0) ? 7 : (m == 1) ? 4 : 3;
    endfunction

    task automatic launch(input bit wr, input logic [1:0] md, input int n);
        @(posedge clk); #1;
        clr_gen++;
        @(negedge clk);
        xfer_start = 1'b1; xfer_write = wr; xfer_mode = md; xfer_words = 16'(n);
        @(negedge clk);
        xfer_start = 1'b0;
        dev_words = n;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && n_done == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_stb(input int k, input int limit);
        for (int i = 0; i < limit && n_stb < k; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        // R1: all pins idle while reset is held
        check("R1", int'({dev_ack_n, dev_rd_n, dev_wr_n, dev_dd_oe, xfer_busy,
                          xfer_done, rx_valid, tx_ready}), 8'b1110_0000, "pins in reset");
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", int'({dev_ack_n, dev_rd_n, dev_wr_n, dev_dd_oe, xfer_busy,
                          xfer_done, rx_valid, tx_ready}), 8'b1110_0000, "pins after reset");
    endtask

    task automatic t_read(input int m, input int n);
        launch(1'b0, 2'(m), n);
        wait_done(4000);
        check("R9", n_stb, n, "read strobe count");
        check("R9", n_done, 1, "done pulses");
        check("R9", int'(xfer_busy), 0, "busy after done");
        check("R3", stb_min, exp_stb(m), "read strobe min width");
        check("R3", stb_max, exp_stb(m), "read strobe max width");
        check("R2", lat_last, 2, "request to acknowledge latency");
        if (n > 1) check_ge("R4", gap_min, exp_cyc(m), "acknowledge spacing");
        check("R6", n_r, n, "words delivered");
        for (int i = 0; i < n && i < 8; i++)
            check("R6", int'(rlog[i]), int'(16'hA500 ^ 16'(i)), "read word value");
    endtask

    task automatic t_write(input int m, input int n);
        launch(1'b1, 2'(m), n);
        wait_done(4000);
        check("R9", n_stb, n, "write strobe count");
        check("R9", n_done, 1, "done pulses");
        check("R3", stb_max, exp_stb(m), "write strobe width");
        check("R5", hold_last, exp_hold(m), "write data hold cycles");
        if (n > 1) check_ge("R4", gap_min, exp_cyc(m), "acknowledge spacing");
        for (int i = 0; i < n && i < 8; i++)
            check("R5", int'(wlog[i]), int'(16'h3C00 + 16'(i)), "write word order");
    endtask

    task automatic t_stall_write();
        src_en = 1'b0;
        launch(1'b1, 2'd2, 2);
        repeat (100) @(negedge clk);
        // R8: request pending, write stream empty
        check("R8", n_stb, 0, "strobes with empty source");
        check("R8", int'(dev_ack_n), 1, "ack with empty source");
        check("R8", int'(xfer_busy), 1, "busy while stalled");
        src_en = 1'b1;
        wait_done(2000);
        check("R8", n_stb, 2, "strobes after source resumes");
        check("R5", int'(wlog[1]), int'(16'h3C01), "second word after stall");
    endtask

    task automatic t_stall_read();
        sink_en = 1'b0;
        launch(1'b0, 2'd2, 2);
        wait_stb(1, 2000);
        repeat (100) @(negedge clk);
        check("R8", n_stb, 1, "strobes with full holding register");
        check("R8", int'(dev_ack_n), 1, "ack with full holding register");
        check("R6", int'(rx_valid), 1, "read word held");
        check("R6", int'(rx_data), int'(16'hA500), "held read value");
        sink_en = 1'b1;
        wait_done(2000);
        check("R8", n_r, 2, "words after sink resumes");
        check("R6", int'(rlog[1]), int'(16'hA501), "second read word");
    endtask

    task automatic t_fresh();
        dev_stick = 1'b1;
        launch(1'b0, 2'd2, 2);
        wait_stb(1, 2000);
        repeat (120) @(negedge clk);
        // R7: request never dropped, so no second word
        check("R7", n_stb, 1, "strobes while request stuck high");
        check("R7", n_ack, 1, "acks while request stuck high");
        check("R7", int'(xfer_busy), 1, "busy while request stuck");
        dev_stick = 1'b0;
        drop_gen++;
        wait_done(2000);
        check("R7", n_stb, 2, "strobes after fresh request");
        check("R9", n_done, 1, "done after fresh request");
    endtask

    task automatic t_mode_latch();
        launch(1'b0, 2'd0, 2);
        xfer_mode = 2'd2;
        wait_done(4000);
        // R3: mode change after start is ignored
        check("R3", stb_min, 60, "width after mode input change");
        check("R3", stb_max, 60, "width after mode input change");
    endtask

    task automatic t_mode3();
        launch(1'b0, 2'd3, 1);
        wait_done(2000);
        check("R3", stb_max, 15, "mode code 3 width");
    endtask

    task automatic t_zero();
        launch(1'b0, 2'd1, 0);
        repeat (20) @(negedge clk);
        check("R9", n_done, 1, "zero count done");
        check("R9", n_stb, 0, "zero count strobes");
        check("R9", int'(xfer_busy), 0, "zero count busy");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        repeat (5) @(negedge clk);
        t_read(0, 2);
        t_read(2, 3);
        t_write(1, 3);
        t_write(2, 2);
        t_write(0, 1);
        t_stall_write();
        t_stall_read();
        t_fresh();
        t_mode_latch();
        t_mode3();
        t_zero();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

endmodule